// File: doc/BRIEF.md
# Distance-Ordered Bank-Set Cache Controller

This block keeps the tags and placement state for a cache whose ways sit in separate banks at increasing distance from the requester. Each of the ways has its own access latency, and nearer banks answer sooner. A lookup is captured through a ready/valid handshake. The controller then compares the tag against every way of the indexed set at the same time. It answers hit or miss once the bank that holds the line would have responded. For a miss, it answers once the furthest bank has responded.

Lines move toward the requester as they are used. A hit in any bank except the nearest one exchanges the hit line with the line in the next nearer bank. A miss always discards the line in the furthest bank and places the new line there. No other copy of the discarded line is kept. If the discarded line was written, it is first offered for write-back. After that, the refill is requested through a simple request/acknowledge pair. Data storage sits outside this block.

Top module: `bank_set_ctrl`

## Requirements
- R1: After reset every line is invalid, `reqReady` is 1, and `rspValid`, `wbValid` and `fillReqValid` are 0. The first lookup of any address misses.
- R2: The set index is `reqAddr[2:0]` and the tag is `reqAddr[15:3]`. The same tag in two different sets occupies two independent lines.
- R3: A hit raises `rspValid` for one cycle with `rspHit`=1 and `rspWay` equal to the way that holds the line. This happens L cycles after the accepting edge, where L is 2, 4, 7 or 11 for ways 0 to 3. Cycle 1 is the cycle right after the accepting edge.
- R4: A miss raises `rspValid` with `rspHit`=0 and `rspWay`=3, 11 cycles after the accepting edge. This is the latency of the furthest bank.
- R5: A hit in way w>0 exchanges the lines in ways w and w-1 in one extra busy cycle. After that, the hit line is found in way w-1 and the former occupant of way w-1 is found in way w.
- R6: A hit in way 0 leaves the set unchanged, and `reqReady` returns to 1 in the cycle after the response.
- R7: On a miss, the line in way 3 is discarded with no copy kept, and the new line is written into way 3. Ways 0 to 2 are not changed.
- R8: If the way-3 victim is valid and dirty, `wbValid` rises with `wbTag` and `wbSet` set to that line's tag and set. It stays high and stable until `wbReady`, and `fillReqValid` stays low during that time.
- R9: After any write-back, `fillReqValid` rises with `fillTag` and `fillSet` set to the request's tag and set, and stays high until `fillAck`. A clean or invalid victim goes straight to this step.
- R10: `reqReady` is 0 from the accepting edge until the lookup, any exchange and any refill have completed.
- R11: A write request marks its line dirty. The dirty mark moves with the line through exchanges, and a write miss fills the line as dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Controller idle, request accepted |
| reqAddr | input | 16 | Line address: tag above, set index in bits 2:0 |
| reqWrite | input | 1 | Request writes the line (marks dirty) |
| rspValid | output | 1 | One-cycle response strobe |
| rspHit | output | 1 | 1 = hit, 0 = miss |
| rspWay | output | 2 | Way that held the line, or way 3 on a miss |
| wbValid | output | 1 | Dirty victim awaiting write-back |
| wbReady | input | 1 | Write-back taken |
| wbTag | output | 13 | Victim tag |
| wbSet | output | 3 | Victim set index |
| fillReqValid | output | 1 | Refill requested |
| fillAck | input | 1 | Refill line delivered |
| fillTag | output | 13 | Tag being refilled |
| fillSet | output | 3 | Set being refilled |

## Verification
The assertions assume that the bank latencies are at least one cycle and do not decrease with distance. They also assume that `wbReady` and `fillAck` matter only while the matching request is raised. The bench keeps one request in flight at a time. It pulses `wbReady` only while `wbValid` is high and `fillAck` only while `fillReqValid` is high, each after a random wait of zero to three cycles. Tags are drawn from a small pool so that hits, promotions into way 0, and evictions of dirty lines all occur often.

// File: rtl/bset_pkg.sv
package bset_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SWAP,
    ST_WB,
    ST_FILL
  } bsetState_e;

  // strobes from control to the tag datapath
  typedef struct packed {
    logic capture;
    logic doSwap;
    logic doFill;
    logic markDirty;
  } bsetStrobe_t;

endpackage

// File: rtl/bset_tags.sv
module bset_tags
  import bset_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  parameter int ADDR_W   = 16,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int TAG_W   = ADDR_W - SET_W,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bsetStrobe_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic              hit,
  output logic [WAY_W-1:0]  hitWay,
  output logic [TAG_W-1:0]  curTag,
  output logic [SET_W-1:0]  curSet,
  output logic              curWrite,
  output logic              victimDirty,
  output logic [TAG_W-1:0]  victimTag
);

  localparam logic [WAY_W-1:0] FAR_WAY = WAY_W'(NUM_WAYS - 1);

  logic [ADDR_W-1:0]   regAddr;
  logic                regWrite;
  logic [TAG_W-1:0]    tagArr   [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] validArr [NUM_SETS];
  logic [NUM_WAYS-1:0] dirtyArr [NUM_SETS];
  logic [NUM_WAYS-1:0] hitVec;
  logic [WAY_W-1:0]    swapDst;
  logic [TAG_W-1:0]    srcTag;

  assign curSet   = regAddr[SET_W-1:0];
  assign curTag   = regAddr[ADDR_W-1:SET_W];
  assign curWrite = regWrite;

  // parallel probe of every way in the set
  generate
    for (genvar gw = 0; gw < NUM_WAYS; gw++) begin : gProbe
      assign hitVec[gw] = validArr[curSet][gw] && (tagArr[curSet][gw] == curTag);
    end
  endgenerate

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end

  assign hit         = |hitVec;
  assign swapDst     = hitWay - WAY_W'(1);
  assign srcTag      = tagArr[curSet][hitWay];
  assign victimDirty = validArr[curSet][FAR_WAY] && dirtyArr[curSet][FAR_WAY];
  assign victimTag   = tagArr[curSet][FAR_WAY];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regAddr  <= '0;
      regWrite <= 1'b0;
    end else if (strb.capture) begin
      regAddr  <= reqAddr;
      regWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) tagArr[s][w] <= '0;
      end
    end else if (strb.doSwap) begin
      tagArr[curSet][hitWay]    <= tagArr[curSet][swapDst];
      tagArr[curSet][swapDst]   <= tagArr[curSet][hitWay];
      validArr[curSet][hitWay]  <= validArr[curSet][swapDst];
      validArr[curSet][swapDst] <= validArr[curSet][hitWay];
      dirtyArr[curSet][hitWay]  <= dirtyArr[curSet][swapDst];
      dirtyArr[curSet][swapDst] <= dirtyArr[curSet][hitWay] | regWrite;
    end else if (strb.doFill) begin
      tagArr[curSet][FAR_WAY]   <= curTag;
      validArr[curSet][FAR_WAY] <= 1'b1;
      dirtyArr[curSet][FAR_WAY] <= regWrite;
    end else if (strb.markDirty) begin
      dirtyArr[curSet][hitWay]  <= 1'b1;
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec)); // R7
  AST_SWAP_PROMOTE: assert property (@(posedge clk) disable iff (!rstN)
    strb.doSwap |=> tagArr[curSet][$past(swapDst)] == $past(srcTag)); // R5
  AST_FILL_FAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.doFill |=> validArr[curSet][FAR_WAY] && (tagArr[curSet][FAR_WAY] == $past(curTag))); // R7

endmodule

// File: rtl/bset_ctrl.sv
module bset_ctrl
  import bset_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int LAT_W    = 8,
  parameter logic [NUM_WAYS*LAT_W-1:0] BANK_LAT = {8'd11, 8'd7, 8'd4, 8'd2},
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             hit,
  input  logic [WAY_W-1:0] hitWay,
  input  logic             curWrite,
  input  logic             victimDirty,
  input  logic             wbReady,
  input  logic             fillAck,
  output logic             rspValid,
  output logic             rspHit,
  output logic [WAY_W-1:0] rspWay,
  output logic             wbValid,
  output logic             fillReqValid,
  output bsetStrobe_t      strb
);

  localparam logic [WAY_W-1:0] FAR_WAY = WAY_W'(NUM_WAYS - 1);

  bsetState_e       state, stateNxt;
  logic [LAT_W-1:0] latCnt;
  logic [LAT_W-1:0] target;
  logic [LAT_W-1:0] latOf [NUM_WAYS];
  logic             done;

  generate
    for (genvar gw = 0; gw < NUM_WAYS; gw++) begin : gLat
      assign latOf[gw] = BANK_LAT[gw*LAT_W +: LAT_W];
    end
  endgenerate

  assign target = hit ? latOf[hitWay] : latOf[FAR_WAY];
  assign done   = (state == ST_WAIT) && (latCnt == target);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNxt = ST_WAIT;
      ST_WAIT: begin
        if (done) begin
          if (hit)              stateNxt = (hitWay == '0) ? ST_IDLE : ST_SWAP;
          else if (victimDirty) stateNxt = ST_WB;
          else                  stateNxt = ST_FILL;
        end
      end
      ST_SWAP: stateNxt = ST_IDLE;
      ST_WB:   if (wbReady) stateNxt = ST_FILL;
      ST_FILL: if (fillAck) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      latCnt <= '0;
    end else begin
      state <= stateNxt;
      if (strb.capture)                latCnt <= LAT_W'(1);
      else if (state == ST_WAIT && !done) latCnt <= latCnt + LAT_W'(1);
    end
  end

  assign reqReady       = (state == ST_IDLE);
  assign rspValid       = done;
  assign rspHit         = hit;
  assign rspWay         = hit ? hitWay : FAR_WAY;
  assign wbValid        = (state == ST_WB);
  assign fillReqValid   = (state == ST_FILL);
  assign strb.capture   = reqValid && (state == ST_IDLE);
  assign strb.doSwap    = (state == ST_SWAP);
  assign strb.doFill    = (state == ST_FILL) && fillAck;
  assign strb.markDirty = done && hit && (hitWay == '0) && curWrite;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady); // R10
  AST_WAY0_NO_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspHit && (rspWay == '0) |=> reqReady); // R6
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid && !fillAck |=> fillReqValid); // R9
  AST_SWAP_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspHit && (rspWay != '0) |=> !reqReady); // R5

endmodule

// File: rtl/bank_set_ctrl.sv
module bank_set_ctrl
  import bset_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  parameter int ADDR_W   = 16,
  parameter int LAT_W    = 8,
  parameter logic [NUM_WAYS*LAT_W-1:0] BANK_LAT = {8'd11, 8'd7, 8'd4, 8'd2},
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int TAG_W   = ADDR_W - SET_W,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WAY_W-1:0]  rspWay,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [TAG_W-1:0]  wbTag,
  output logic [SET_W-1:0]  wbSet,
  output logic              fillReqValid,
  input  logic              fillAck,
  output logic [TAG_W-1:0]  fillTag,
  output logic [SET_W-1:0]  fillSet
);

  bsetStrobe_t      strb;
  logic             hit;
  logic [WAY_W-1:0] hitWay;
  logic [TAG_W-1:0] curTag;
  logic [SET_W-1:0] curSet;
  logic             curWrite;
  logic             victimDirty;
  logic [TAG_W-1:0] victimTag;

  bset_tags #(
    .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W)
  ) uTags (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .hit(hit), .hitWay(hitWay), .curTag(curTag), .curSet(curSet),
    .curWrite(curWrite), .victimDirty(victimDirty), .victimTag(victimTag)
  );

  bset_ctrl #(
    .NUM_WAYS(NUM_WAYS), .LAT_W(LAT_W), .BANK_LAT(BANK_LAT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .hit(hit), .hitWay(hitWay), .curWrite(curWrite), .victimDirty(victimDirty),
    .wbReady(wbReady), .fillAck(fillAck), .rspValid(rspValid), .rspHit(rspHit),
    .rspWay(rspWay), .wbValid(wbValid), .fillReqValid(fillReqValid), .strb(strb)
  );

  assign wbTag   = victimTag;
  assign wbSet   = curSet;
  assign fillTag = curTag;
  assign fillSet = curSet;

  // independent cycle count since the accepting edge
  logic [15:0] sinceAcc;
  logic [LAT_W-1:0] expLat;

  always_ff @(posedge clk) begin
    if (!rstN)                      sinceAcc <= '0;
    else if (reqValid && reqReady)  sinceAcc <= 16'd1;
    else if (sinceAcc != 16'hFFFF && sinceAcc != 16'd0) sinceAcc <= sinceAcc + 16'd1;
  end

  assign expLat = rspHit ? BANK_LAT[rspWay*LAT_W +: LAT_W]
                         : BANK_LAT[(NUM_WAYS-1)*LAT_W +: LAT_W];

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> sinceAcc == 16'(expLat)); // R3
  AST_MISS_FAR: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspHit |-> rspWay == WAY_W'(NUM_WAYS - 1)); // R4
  AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !fillReqValid); // R8
  AST_WB_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    wbValid && !wbReady |=> wbValid && $stable(wbTag) && $stable(wbSet)); // R8

endmodule

// File: tb/tb_bank_set_ctrl.sv
`timescale 1ns/1ps
module tb_bank_set_ctrl;

  localparam int ADDR_W = 16;
  localparam int SET_W  = 3;
  localparam int TAG_W  = 13;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqWrite = 1'b0;
  logic              rspValid, rspHit;
  logic [1:0]        rspWay;
  logic              wbValid;
  logic              wbReady = 1'b0;
  logic [TAG_W-1:0]  wbTag;
  logic [SET_W-1:0]  wbSet;
  logic              fillReqValid;
  logic              fillAck = 1'b0;
  logic [TAG_W-1:0]  fillTag;
  logic [SET_W-1:0]  fillSet;

  int checks = 0;
  int errors = 0;

  bit mValid [8][4];
  int mTag   [8][4];
  bit mDirty [8][4];

  always #2.5 clk = ~clk;

  bank_set_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .rspValid(rspValid), .rspHit(rspHit),
    .rspWay(rspWay), .wbValid(wbValid), .wbReady(wbReady), .wbTag(wbTag),
    .wbSet(wbSet), .fillReqValid(fillReqValid), .fillAck(fillAck),
    .fillTag(fillTag), .fillSet(fillSet)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int latOf(input int w);
    case (w)
      0: return 2;
      1: return 4;
      2: return 7;
      default: return 11;
    endcase
  endfunction

  function automatic int findWay(input int s, input int t);
    for (int w = 0; w < 4; w++) if (mValid[s][w] && mTag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic doReq(input int s, input int t, input bit wr);
    int w, lat, cyc, d;
    bit vDirty, tb, td;
    int tt;
    w = findWay(s, t);
    lat = (w >= 0) ? latOf(w) : latOf(3);
    @(negedge clk);
    chk(reqReady == 1'b1, "R10 idle", int'(reqReady), 1);
    reqValid = 1'b1;
    reqAddr  = ADDR_W'((t << SET_W) | s);
    reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    reqWrite = 1'b0;
    cyc = 1;
    while (!rspValid && cyc < 64) begin
      chk(reqReady == 1'b0, "R10 busy", int'(reqReady), 0);
      @(negedge clk);
      cyc++;
    end
    chk(cyc == lat, (w >= 0) ? "R3 latency" : "R4 latency", cyc, lat);
    chk(rspHit == (w >= 0), (w >= 0) ? "R3 hit" : "R1/R2/R4 miss", int'(rspHit), int'(w >= 0));
    chk(int'(rspWay) == ((w >= 0) ? w : 3), (w >= 0) ? "R3/R5 way" : "R4/R7 way",
        int'(rspWay), (w >= 0) ? w : 3);
    if (w > 0) begin
      @(negedge clk);
      chk(reqReady == 1'b0, "R5 swap busy", int'(reqReady), 0);
      tb = mValid[s][w]; tt = mTag[s][w]; td = mDirty[s][w];
      mValid[s][w] = mValid[s][w-1]; mTag[s][w] = mTag[s][w-1]; mDirty[s][w] = mDirty[s][w-1];
      mValid[s][w-1] = tb; mTag[s][w-1] = tt; mDirty[s][w-1] = td | wr;
    end else if (w == 0) begin
      @(negedge clk);
      chk(reqReady == 1'b1, "R6 no swap", int'(reqReady), 1);
      mDirty[s][0] = mDirty[s][0] | wr;
    end else begin
      vDirty = mValid[s][3] && mDirty[s][3];
      @(negedge clk);
      if (vDirty) begin
        chk(wbValid == 1'b1, "R8/R11 wb", int'(wbValid), 1);
        chk(int'(wbTag) == mTag[s][3], "R8 wbTag", int'(wbTag), mTag[s][3]);
        chk(int'(wbSet) == s, "R8 wbSet", int'(wbSet), s);
        chk(fillReqValid == 1'b0, "R8 order", int'(fillReqValid), 0);
        d = int'($urandom_range(0, 3));
        repeat (d) begin
          @(negedge clk);
          chk(wbValid == 1'b1, "R8 hold", int'(wbValid), 1);
        end
        wbReady = 1'b1;
        @(negedge clk);
        wbReady = 1'b0;
      end else begin
        chk(wbValid == 1'b0, "R9 no wb", int'(wbValid), 0);
      end
      chk(fillReqValid == 1'b1, "R9 fill", int'(fillReqValid), 1);
      chk(int'(fillTag) == t, "R9 fillTag", int'(fillTag), t);
      chk(int'(fillSet) == s, "R9 fillSet", int'(fillSet), s);
      d = int'($urandom_range(0, 3));
      repeat (d) begin
        @(negedge clk);
        chk(fillReqValid == 1'b1, "R9 hold", int'(fillReqValid), 1);
      end
      fillAck = 1'b1;
      @(negedge clk);
      fillAck = 1'b0;
      mValid[s][3] = 1'b1; mTag[s][3] = t; mDirty[s][3] = wr;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready", int'(reqReady), 1);
    chk(rspValid == 1'b0, "R1 rsp", int'(rspValid), 0);
    chk(wbValid == 1'b0, "R1 wb", int'(wbValid), 0);
    chk(fillReqValid == 1'b0, "R1 fill", int'(fillReqValid), 0);

    // R1: cold miss; R2: same tag in two sets is independent
    doReq(0, 5, 1'b1);
    doReq(1, 5, 1'b0);
    doReq(0, 5, 1'b0);
    // R5/R6: promote one line to way 0, then hit it there
    doReq(2, 1, 1'b0);
    doReq(2, 1, 1'b0);
    doReq(2, 1, 1'b0);
    doReq(2, 1, 1'b1);
    doReq(2, 1, 1'b0);
    doReq(2, 1, 1'b0);
    // R7/R8/R11: dirty line in way 3 is evicted and written back
    doReq(3, 9, 1'b1);
    doReq(3, 10, 1'b0);
    doReq(3, 9, 1'b0);
    doReq(3, 11, 1'b0);
    doReq(3, 12, 1'b0);

    for (int i = 0; i < 600; i++) begin
      doReq(int'($urandom_range(0, 7)), int'($urandom_range(0, 6)), 1'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule